// File: doc/BRIEF.md
# Serial NOR Flash Sequencer

This block is a single-lane serial master that runs complete NOR flash operations on its own. A requester hands over one operation (identification read, status read, data read, page program or sector erase) with a 24-bit address and a byte count through a valid/ready request port. The block then produces every chip-select frame that operation needs. It adds a write-enable frame before array-changing operations and polls the device status until the busy bit clears. It ends the operation with a single done pulse.

Program data arrives on a byte-wide valid/ready stream and is pulled only while a frame is open. Bytes received from the device leave on a byte-wide stream qualified by a one-cycle valid strobe. The serial clock comes from a system-clock divider whose half-period is programmable. The write-protect and reset lines toward the device are held inactive (high) at all times.

The states are IDLE, WEN (write-enable frame), GAP (chip select high between frames), CMD (opcode byte), ADDR (three address bytes), WFETCH (wait for a program byte), WDAT (shift a program byte), RDAT (shift in a data byte), PCMD (poll opcode), PRD (poll status byte) and DONE. The transitions are as follows:
- IDLE goes to WEN for program and erase, to CMD for the other operations, and stays in IDLE on a rejected request.
- WEN goes to GAP and then to CMD.
- CMD goes to RDAT for identification and status reads, and to ADDR for the others.
- ADDR goes to RDAT for a read, to WFETCH for a program, and to GAP and then PCMD for an erase.
- WFETCH and WDAT alternate until the count is used up, then go to GAP and then PCMD.
- RDAT goes to GAP and then DONE when its last byte is in.
- PCMD goes to PRD. PRD goes to GAP, then back to PCMD while the device is busy, or to DONE once it is idle.
- DONE goes to IDLE.

Top module: `nor_flash_ctl`

## Requirements
- R1: While chip select (active low) is high, the serial clock is low. The write-protect and reset outputs are always high.
- R2: Bytes are shifted most significant bit first. The output bit changes only while the serial clock is low. The input bit is sampled at the end of the clock-high half.
- R3: Each serial clock half-period lasts `clk_div`+1 system clock cycles.
- R4: Operation code 0 (identification) sends 0x9F and then streams out three received bytes in arrival order: manufacturer, memory type, capacity.
- R5: Operation code 1 (status) sends 0x05 and then streams out one received byte.
- R6: Operation code 2 (read) sends 0x03, then the address high byte first, then streams out `req_len` received bytes, all inside one frame.
- R7: Operation code 3 (program) first sends 0x06 alone in its own frame. It then sends 0x02, the address and `req_len` bytes taken from the write stream. It then repeats 0x05 status frames until bit 0 of the status byte reads 0, and only after that gives done.
- R8: A request is rejected if it has an operation code above 4, a read or program length of 0, or a program length above 256. A rejected request gives done together with error on the next cycle, and chip select never falls.
- R9: Operation code 4 (erase) sends 0x06 in its own frame, then 0x20 with the address, then polls status as in R7 before done.
- R10: Chip select stays high for at least `clk_div`+1 cycles between any two frames.
- R11: Done is a one-cycle pulse per accepted request. Error is only ever high together with done. `req_ready` is high only while no frame is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | DIV_W | Serial half-period minus one, in system cycles |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_op | input | 3 | Operation code (0 id, 1 status, 2 read, 3 program, 4 erase) |
| req_addr | input | 24 | Flash byte address |
| req_len | input | LEN_W | Byte count for read and program |
| wr_data | input | 8 | Program byte |
| wr_valid | input | 1 | Program byte offered |
| wr_ready | output | 1 | Program byte taken when high with wr_valid |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Operation rejected, valid with done |
| flash_cs_n | output | 1 | Chip select, active low |
| flash_sck | output | 1 | Serial clock |
| flash_sdo | output | 1 | Data toward the device |
| flash_sdi | input | 1 | Data from the device |
| flash_wp_n | output | 1 | Write protect, held high |
| flash_rst_n | output | 1 | Device reset, held high |

## Verification
The assertions assume that `clk_div` stays constant while an operation runs, and that the device changes its data line only after a falling serial clock edge. The stimulus changes the divider only between operations. The device model in the bench drives its data line only on falling clock edges. The request fields are held steady for the whole accept cycle. Random addresses and lengths are drawn so that every transfer fits inside the one 4 KB sector that the model stores.

// File: rtl/nor_ctl_pkg.sv
package nor_ctl_pkg;

    localparam logic [2:0] OP_ID    = 3'd0;
    localparam logic [2:0] OP_STAT  = 3'd1;
    localparam logic [2:0] OP_READ  = 3'd2;
    localparam logic [2:0] OP_PROG  = 3'd3;
    localparam logic [2:0] OP_ERASE = 3'd4;

    localparam logic [7:0] CMD_WEN  = 8'h06;
    localparam logic [7:0] CMD_STAT = 8'h05;

    typedef enum logic [3:0] {
        ST_IDLE, ST_WEN, ST_GAP, ST_CMD, ST_ADDR, ST_WFETCH,
        ST_WDAT, ST_RDAT, ST_PCMD, ST_PRD, ST_DONE
    } nor_st_e;

    function automatic logic [7:0] op_code(input logic [2:0] op);
        case (op)
            OP_ID:    return 8'h9F;
            OP_STAT:  return 8'h05;
            OP_READ:  return 8'h03;
            OP_PROG:  return 8'h02;
            default:  return 8'h20;
        endcase
    endfunction

endpackage

// File: rtl/nor_bit_shifter.sv
module nor_bit_shifter #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             start,
    input  logic [7:0]       tx,
    input  logic             sdi,
    output logic             sck,
    output logic             sdo,
    output logic             fin,
    output logic [7:0]       rx
);
    logic             act;
    logic [DIV_W-1:0] cnt;
    logic [2:0]       bitn;
    logic [7:0]       sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act  <= 1'b0;
            sck  <= 1'b0;
            cnt  <= '0;
            bitn <= '0;
            sh   <= '0;
            fin  <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (start && !act) begin
                act  <= 1'b1;
                sh   <= tx;
                cnt  <= '0;
                bitn <= '0;
                sck  <= 1'b0;
            end else if (act) begin
                if (cnt == div) begin
                    cnt <= '0;
                    if (!sck) begin
                        sck <= 1'b1;
                    end else begin
                        sck  <= 1'b0;
                        sh   <= {sh[6:0], sdi};
                        bitn <= bitn + 3'd1;
                        if (bitn == 3'd7) begin
                            act <= 1'b0;
                            fin <= 1'b1;
                        end
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign sdo = act ? sh[7] : 1'b0;
    assign rx  = sh;

endmodule

// File: rtl/nor_flash_ctl.sv
module nor_flash_ctl
    import nor_ctl_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int LEN_W      = 16,
    parameter int PAGE_BYTES = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_op,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             done,
    output logic             err,
    output logic             flash_cs_n,
    output logic             flash_sck,
    output logic             flash_sdo,
    input  logic             flash_sdi,
    output logic             flash_wp_n,
    output logic             flash_rst_n
);
    localparam logic [LEN_W-1:0] PAGE_MAX = LEN_W'(PAGE_BYTES);
    localparam logic [LEN_W-1:0] LEN_ONE  = LEN_W'(1);

    nor_st_e          state, ret;
    logic [2:0]       op_q;
    logic [23:0]      addr_q;
    logic [LEN_W-1:0] left;
    logic [1:0]       aidx;
    logic [7:0]       tx_q;
    logic             kick;
    logic [DIV_W-1:0] gcnt;
    logic             sh_fin;
    logic [7:0]       sh_rx;
    logic             bad;

    nor_bit_shifter #(.DIV_W(DIV_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .div(clk_div), .start(kick), .tx(tx_q),
        .sdi(flash_sdi), .sck(flash_sck), .sdo(flash_sdo), .fin(sh_fin), .rx(sh_rx)
    );

    assign bad = (req_op > OP_ERASE)
              || ((req_op == OP_READ || req_op == OP_PROG) && req_len == '0)
              || (req_op == OP_PROG && req_len > PAGE_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ret      <= ST_IDLE;
            op_q     <= '0;
            addr_q   <= '0;
            left     <= '0;
            aidx     <= '0;
            tx_q     <= '0;
            kick     <= 1'b0;
            gcnt     <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            kick     <= 1'b0;
            rd_valid <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    op_q   <= req_op;
                    addr_q <= req_addr;
                    left   <= req_len;
                    if (bad) begin
                        done <= 1'b1;
                        err  <= 1'b1;
                    end else if (req_op == OP_PROG || req_op == OP_ERASE) begin
                        state <= ST_WEN;
                        tx_q  <= CMD_WEN;
                        kick  <= 1'b1;
                    end else begin
                        state <= ST_CMD;
                        tx_q  <= op_code(req_op);
                        kick  <= 1'b1;
                    end
                end
                ST_WEN: if (sh_fin) begin
                    state <= ST_GAP;
                    ret   <= ST_CMD;
                    tx_q  <= op_code(op_q);
                    gcnt  <= '0;
                end
                ST_GAP: begin
                    if (gcnt == clk_div) begin
                        state <= ret;
                        kick  <= (ret != ST_DONE);
                    end else begin
                        gcnt <= gcnt + 1'b1;
                    end
                end
                ST_CMD: if (sh_fin) begin
                    kick <= 1'b1;
                    if (op_q == OP_ID || op_q == OP_STAT) begin
                        state <= ST_RDAT;
                        tx_q  <= '0;
                        left  <= (op_q == OP_ID) ? LEN_W'(3) : LEN_ONE;
                    end else begin
                        state <= ST_ADDR;
                        aidx  <= 2'd2;
                        tx_q  <= addr_q[23:16];
                    end
                end
                ST_ADDR: if (sh_fin) begin
                    if (aidx != 2'd0) begin
                        aidx <= aidx - 2'd1;
                        tx_q <= (aidx == 2'd2) ? addr_q[15:8] : addr_q[7:0];
                        kick <= 1'b1;
                    end else if (op_q == OP_READ) begin
                        state <= ST_RDAT;
                        tx_q  <= '0;
                        kick  <= 1'b1;
                    end else if (op_q == OP_PROG) begin
                        state <= ST_WFETCH;
                    end else begin
                        state <= ST_GAP;
                        ret   <= ST_PCMD;
                        tx_q  <= CMD_STAT;
                        gcnt  <= '0;
                    end
                end
                ST_WFETCH: if (wr_valid) begin
                    tx_q  <= wr_data;
                    kick  <= 1'b1;
                    state <= ST_WDAT;
                end
                ST_WDAT: if (sh_fin) begin
                    left <= left - 1'b1;
                    if (left == LEN_ONE) begin
                        state <= ST_GAP;
                        ret   <= ST_PCMD;
                        tx_q  <= CMD_STAT;
                        gcnt  <= '0;
                    end else begin
                        state <= ST_WFETCH;
                    end
                end
                ST_RDAT: if (sh_fin) begin
                    rd_data  <= sh_rx;
                    rd_valid <= 1'b1;
                    left     <= left - 1'b1;
                    if (left == LEN_ONE) begin
                        state <= ST_GAP;
                        ret   <= ST_DONE;
                        gcnt  <= '0;
                    end else begin
                        tx_q <= '0;
                        kick <= 1'b1;
                    end
                end
                ST_PCMD: if (sh_fin) begin
                    state <= ST_PRD;
                    tx_q  <= '0;
                    kick  <= 1'b1;
                end
                ST_PRD: if (sh_fin) begin
                    state <= ST_GAP;
                    gcnt  <= '0;
                    if (sh_rx[0]) begin
                        ret  <= ST_PCMD;
                        tx_q <= CMD_STAT;
                    end else begin
                        ret <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready   = (state == ST_IDLE);
        wr_ready    = (state == ST_WFETCH);
        flash_cs_n  = (state == ST_IDLE) || (state == ST_GAP) || (state == ST_DONE);
        flash_wp_n  = 1'b1;
        flash_rst_n = 1'b1;
    end

endmodule

// File: rtl/nor_flash_ctl_chk.sv
module nor_flash_ctl_chk #(
    parameter int DIV_W      = 8,
    parameter int LEN_W      = 16,
    parameter int PAGE_BYTES = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] clk_div,
    input logic             req_valid,
    input logic             req_ready,
    input logic [2:0]       req_op,
    input logic [LEN_W-1:0] req_len,
    input logic             wr_ready,
    input logic             done,
    input logic             err,
    input logic             flash_cs_n,
    input logic             flash_sck,
    input logic             flash_sdo
);
    logic [DIV_W:0] hi_run;
    logic           reject;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hi_run <= '0;
        else if (flash_sck) hi_run <= hi_run + 1'b1;
        else                hi_run <= '0;
    end

    assign reject = (req_op > 3'd4)
                 || ((req_op == 3'd2 || req_op == 3'd3) && req_len == '0)
                 || (req_op == 3'd3 && req_len > LEN_W'(PAGE_BYTES));

    AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        flash_cs_n |-> !flash_sck);  // R1
    AST_SDO_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_cs_n && flash_sck) |-> $stable(flash_sdo));  // R2
    AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        flash_sck |-> (hi_run <= {1'b0, clk_div}));  // R3
    AST_WR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> !flash_cs_n);  // R7
    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && reject) |=> (flash_cs_n && done && err));  // R8
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);  // R11
    AST_NO_ACCEPT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_cs_n |-> !req_ready);  // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |=> !done);  // R11

endmodule

bind nor_flash_ctl nor_flash_ctl_chk #(
    .DIV_W(DIV_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_len(req_len),
    .wr_ready(wr_ready), .done(done), .err(err), .flash_cs_n(flash_cs_n),
    .flash_sck(flash_sck), .flash_sdo(flash_sdo)
);

// File: tb/sim_nor_flash_ctl.sv
`timescale 1ns/1ps
module sim_nor_flash_ctl;
    localparam int DIV_W = 8;
    localparam int LEN_W = 16;
    localparam logic [7:0] ID0 = 8'hA5, ID1 = 8'h3C, ID2 = 8'h16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [DIV_W-1:0] clk_div = 8'd2;
    logic req_valid = 1'b0, req_ready;
    logic [2:0] req_op = '0;
    logic [23:0] req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic [7:0] wr_data = '0;
    logic wr_valid = 1'b0, wr_ready;
    logic [7:0] rd_data;
    logic rd_valid, done, err;
    logic flash_cs_n, flash_sck, flash_sdo, flash_wp_n, flash_rst_n;
    logic flash_sdi = 1'b0;

    always #5 clk = ~clk;

    nor_flash_ctl u0 (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .req_valid(req_valid),
        .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr),
        .req_len(req_len), .wr_data(wr_data), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
        .done(done), .err(err), .flash_cs_n(flash_cs_n), .flash_sck(flash_sck),
        .flash_sdo(flash_sdo), .flash_sdi(flash_sdi), .flash_wp_n(flash_wp_n),
        .flash_rst_n(flash_rst_n)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- device model ----------------
    logic [7:0] fmem [0:4095];
    logic [7:0] sh_in, cmd, ob;
    logic [23:0] fa;
    int bitc = 0, bi = 0, busy = 0, stat_frames = 0, cs_falls = 0, wen_bad = 0;
    bit wel = 0;

    task automatic model_byte(input logic [7:0] b);
        if (bi == 0) begin
            cmd = b;
            ob = (b == 8'h9F) ? ID0 : (b == 8'h05) ? {7'd0, busy > 0} : 8'h00;
        end else begin
            ob = 8'h00;
            if (cmd == 8'h9F) ob = (bi == 1) ? ID1 : (bi == 2) ? ID2 : 8'h00;
            else if (cmd == 8'h03 || cmd == 8'h02 || cmd == 8'h20) begin
                if (bi <= 3) fa = {fa[15:0], b};
                if (cmd == 8'h03 && bi >= 3) begin
                    if (bi > 3) fa = fa + 24'd1;
                    ob = fmem[fa[11:0]];
                end
                if (cmd == 8'h02 && bi >= 4) begin
                    fmem[fa[11:0]] = fmem[fa[11:0]] & b;
                    fa = fa + 24'd1;
                end
            end
        end
    endtask

    always @(negedge flash_cs_n) begin
        bitc = 0; bi = 0; ob = 8'h00; cs_falls++;
    end
    always @(posedge flash_sck) if (!flash_cs_n) begin
        sh_in = {sh_in[6:0], flash_sdo};
        bitc++;
        if (bitc == 8) begin
            bitc = 0;
            model_byte(sh_in);
            bi++;
        end
    end
    always @(negedge flash_sck) if (!flash_cs_n) flash_sdi = ob[7-bitc];
    always @(posedge flash_cs_n) if (bi > 0) begin
        if (cmd == 8'h06) begin
            if (bi == 1) wel = 1; else wen_bad++;
        end else if (cmd == 8'h02 || cmd == 8'h20) begin
            if (!wel) wen_bad++;
            wel = 0;
            busy = 3;
            if (cmd == 8'h20) for (int i = 0; i < 4096; i++) fmem[i] = 8'hFF;
        end else if (cmd == 8'h05) begin
            stat_frames++;
            if (busy > 0) busy--;
        end
        bi = 0;
    end

    // ---------------- timing monitors (R3, R10) ----------------
    int gap_run = 1000, hi_len = 0, gap_bad = 0, half_bad = 0, half_seen = 0;
    always @(negedge clk) if (rst_n) begin
        if (flash_cs_n) gap_run++;
        else begin
            if (gap_run > 0 && gap_run < int'(clk_div) + 1) gap_bad++;
            gap_run = 0;
        end
        if (flash_sck) hi_len++;
        else if (hi_len > 0) begin
            half_seen++;
            if (hi_len != int'(clk_div) + 1) half_bad++;
            hi_len = 0;
        end
    end

    // ---------------- streams ----------------
    logic [7:0] wr_q[$];
    logic [7:0] rd_q[$];
    always @(posedge clk) if (wr_valid && wr_ready) void'(wr_q.pop_front());
    always @(negedge clk) begin
        wr_valid = (wr_q.size() > 0);
        wr_data  = (wr_q.size() > 0) ? wr_q[0] : 8'h00;
        if (rd_valid) rd_q.push_back(rd_data);
    end

    logic [7:0] exp_mem [0:4095];

    task automatic run_op(input logic [2:0] op, input logic [23:0] a,
                          input int len, output bit e);
        rd_q.delete();
        @(negedge clk);
        req_valid = 1; req_op = op; req_addr = a; req_len = LEN_W'(len);
        do @(posedge clk); while (!req_ready);
        @(negedge clk);
        req_valid = 0;
        while (!done) @(negedge clk);
        e = err;
        @(negedge clk);
    endtask

    task automatic do_prog(input int a, input int len, input string rq);
        bit e; int s0;
        for (int i = 0; i < len; i++) begin
            logic [7:0] v = 8'($urandom);
            wr_q.push_back(v);
            exp_mem[a+i] = exp_mem[a+i] & v;
        end
        s0 = stat_frames;
        run_op(3'd3, 24'(a), len, e);
        check(!e, rq, "program error flag", int'(e), 0);
        check(busy == 0 && stat_frames - s0 == 4, rq, "status polls before done",
              stat_frames - s0, 4);
    endtask

    task automatic do_read(input int a, input int len, input string rq);
        bit e; int bad_i = -1;
        run_op(3'd2, 24'(a), len, e);
        check(!e && rd_q.size() == len, rq, "read byte count", rd_q.size(), len);
        for (int i = 0; i < len && i < rd_q.size(); i++)
            if (bad_i < 0 && rd_q[i] != exp_mem[a+i]) bad_i = i;
        check(bad_i < 0, rq, "read data",
              (bad_i < 0) ? 0 : int'(rd_q[bad_i]), (bad_i < 0) ? 0 : int'(exp_mem[a+bad_i]));
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit e; int f0, s0;
        void'($urandom(32'd1234));
        for (int i = 0; i < 4096; i++) begin fmem[i] = 8'h00; exp_mem[i] = 8'h00; end
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 / R11 reset state
        check(flash_cs_n && !flash_sck && flash_wp_n && flash_rst_n, "R1", "idle pins",
              {flash_cs_n, flash_sck, flash_wp_n, flash_rst_n}, 4'b1011);
        check(req_ready && !done && !err, "R11", "reset handshake", req_ready, 1);

        // R4 identification
        run_op(3'd0, 24'd0, 0, e);
        check(!e && rd_q.size() == 3 && rd_q[0] == ID0 && rd_q[1] == ID1 && rd_q[2] == ID2,
              "R4", "id bytes", (rd_q.size() == 3) ? {rd_q[0], rd_q[1], rd_q[2]} : 0,
              {ID0, ID1, ID2});

        // R5 status read on idle device
        s0 = stat_frames;
        run_op(3'd1, 24'd0, 0, e);
        check(!e && rd_q.size() == 1 && rd_q[0] == 8'h00 && stat_frames - s0 == 1,
              "R5", "status byte", (rd_q.size() > 0) ? rd_q[0] : 9'h100, 0);

        // R9 erase with write enable and polling
        s0 = stat_frames;
        run_op(3'd4, 24'h000100, 0, e);
        for (int i = 0; i < 4096; i++) exp_mem[i] = 8'hFF;
        check(!e && busy == 0 && stat_frames - s0 == 4, "R9", "erase polls",
              stat_frames - s0, 4);
        check(wen_bad == 0, "R9", "write enable frame before erase", wen_bad, 0);
        do_read(24'h000100, 8, "R9");

        // R7 full page and R6 read back
        do_prog(0, 256, "R7");
        check(wen_bad == 0, "R7", "write enable frame before program", wen_bad, 0);
        do_read(0, 256, "R6");

        // R8 rejections
        f0 = cs_falls;
        run_op(3'd3, 24'd0, 257, e);
        check(e && cs_falls == f0, "R8", "257-byte program rejected", cs_falls - f0, 0);
        run_op(3'd2, 24'd0, 0, e);
        check(e && cs_falls == f0, "R8", "zero-length read rejected", int'(e), 1);
        run_op(3'd3, 24'd0, 0, e);
        check(e && cs_falls == f0, "R8", "zero-length program rejected", int'(e), 1);
        run_op(3'd6, 24'd0, 4, e);
        check(e && cs_falls == f0, "R8", "unknown op rejected", int'(e), 1);

        // R3 with another divider, R2 through data patterns
        clk_div = 8'd4;
        do_prog(1024, 3, "R2");
        do_read(1024, 3, "R2");
        clk_div = 8'd0;
        do_read(0, 5, "R6");
        clk_div = 8'd2;

        // random program/read mix
        for (int k = 0; k < 6; k++) begin
            int a = 256 + int'($urandom_range(0, 3700));
            int n = int'($urandom_range(1, 24));
            do_prog(a, n, "R7");
            do_read(a, n, "R6");
        end

        check(half_seen > 0 && half_bad == 0, "R3", "clock high half length", half_bad, 0);
        check(gap_bad == 0, "R10", "deselect gap", gap_bad, 0);
        check(wen_bad == 0, "R7", "write enable totals", wen_bad, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule